// File: doc/BRIEF.md
# APM Command SMI/SCI Controller

This block sits behind the APM command port of a power-management function. Software writes a one-byte command to that port. Two reserved codes switch the ACPI SCI-enable flag and are fully handled inside the block. Every other code is treated as a request for system-management mode. It raises a sticky SMI request, but only when the SMI-enable bit in the local configuration dword is set.

The block owns a four-byte configuration dword, which is configuration bytes 0x58 to 0x5B. It is written through a byte-enabled port that is separate from the APM port, and it is read back without delay. The SMI request stays high until the SMM side pulses the clear input. The SCI-enable flag is driven out for the SCI routing logic. When the parameter `SMM_PRESENT` is 0, reset presets the SMI-enable bit. Non-ACPI commands then raise SMI without any software setup.

Top module: `apm_smi_ctrl`

## Requirements
- R1: After reset with `SMM_PRESENT`=1, `sci_en_o`=0, `smi_o`=0 and `cfg_rdata_o`=0x00000000.
- R2: With `SMM_PRESENT`=0, reset leaves `cfg_rdata_o`=0x02000000, so the SMI-enable bit (bit 1 of byte 3, dword bit 25) is already set.
- R3: An APM write of 0xF1 sets `sci_en_o` on the next cycle, and an APM write of 0xF0 clears it on the next cycle. Other codes leave it unchanged.
- R4: APM writes of 0xF0 or 0xF1 never raise `smi_o`, whatever the SMI-enable bit holds.
- R5: An APM write of any code other than 0xF0 or 0xF1 sets `smi_o` on the next cycle when dword bit 25 is 1.
- R6: With dword bit 25 at 0, such a write leaves `smi_o` low.
- R7: Once set, `smi_o` holds until `smi_clr_i` is high at a clock edge, and it is low on the following cycle.
- R8: When an SMI-raising APM write and `smi_clr_i` occur in the same cycle, `smi_o` is 1 afterwards.
- R9: A configuration write updates only the bytes whose bit in `cfg_be_i` is 1, with bit n selecting data bits 8n+7:8n. `cfg_rdata_o` shows the new value on the next cycle.
- R10: An APM write is gated by the SMI-enable value held before a configuration write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| apm_wr_i | input | 1 | APM command write strobe |
| apm_data_i | input | 8 | APM command byte |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_be_i | input | 4 | Byte enables for the configuration write |
| cfg_wdata_i | input | 32 | Configuration write data, bytes 0x58..0x5B |
| cfg_rdata_o | output | 32 | Current configuration dword |
| smi_clr_i | input | 1 | Clears the SMI request |
| smi_o | output | 1 | Sticky SMI request |
| sci_en_o | output | 1 | ACPI SCI-enable flag |

## Verification
The hardest case to reach from the ports is a collision on one clock edge: an SMI-raising command meeting either the clear input or a configuration write that flips the enable bit. The stimulus drives both inputs in the same cycle, in both enable directions. Every one of the 256 command codes is also swept with the enable bit set and with it cleared. Separately, a second instance built without SMM support is checked right after reset: with no setup at all, a plain command on that instance must raise SMI.

// File: rtl/apm_smi_pkg.sv
package apm_smi_pkg;
  localparam logic [7:0] APM_ACPI_ON  = 8'hF1;
  localparam logic [7:0] APM_ACPI_OFF = 8'hF0;
  localparam int SMI_EN_BYTE = 3;
  localparam int SMI_EN_BIT  = 1;
  localparam int SMI_EN_POS  = SMI_EN_BYTE * 8 + SMI_EN_BIT;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_SCI_ON,
    CMD_SCI_OFF,
    CMD_SMI
  } apm_cmd_e;
endpackage

// File: rtl/apm_cfg_regs.sv
module apm_cfg_regs
  import apm_smi_pkg::*;
#(
  parameter bit SMM_PRESENT = 1'b1,
  parameter int CFG_BYTES   = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic [CFG_BYTES-1:0]   be_i,
  input  logic [CFG_BYTES*8-1:0] wdata_i,
  output logic [CFG_BYTES*8-1:0] cfg_o,
  output logic                   smi_en_o
);
  for (genvar i = 0; i < CFG_BYTES; i++) begin : g_byte
    // without SMM the enable bit is preset so commands reach the SMI line
    localparam logic [7:0] RST_VAL =
      (!SMM_PRESENT && i == SMI_EN_BYTE) ? 8'(1 << SMI_EN_BIT) : 8'h00;
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             q <= RST_VAL;
      else if (wr_i && be_i[i]) q <= wdata_i[i*8 +: 8];
    end
    assign cfg_o[i*8 +: 8] = q;
  end

  assign smi_en_o = cfg_o[SMI_EN_POS];
endmodule

// File: rtl/apm_cmd_decode.sv
module apm_cmd_decode
  import apm_smi_pkg::*;
(
  input  logic       wr_i,
  input  logic [7:0] data_i,
  output apm_cmd_e   cmd_o
);
  always_comb begin
    if (!wr_i)                     cmd_o = CMD_NONE;
    else if (data_i == APM_ACPI_ON)  cmd_o = CMD_SCI_ON;
    else if (data_i == APM_ACPI_OFF) cmd_o = CMD_SCI_OFF;
    else                           cmd_o = CMD_SMI;
  end
endmodule

// File: rtl/apm_flag_ctrl.sv
module apm_flag_ctrl
  import apm_smi_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  apm_cmd_e cmd_i,
  input  logic     smi_en_i,
  input  logic     smi_clr_i,
  output logic     sci_en_o,
  output logic     smi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sci_en_o <= 1'b0;
    end else begin
      case (cmd_i)
        CMD_SCI_ON:  sci_en_o <= 1'b1;
        CMD_SCI_OFF: sci_en_o <= 1'b0;
        default:     sci_en_o <= sci_en_o;
      endcase
    end
  end

  // a new request wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           smi_o <= 1'b0;
    else if (cmd_i == CMD_SMI && smi_en_i) smi_o <= 1'b1;
    else if (smi_clr_i)                    smi_o <= 1'b0;
  end
endmodule

// File: rtl/apm_smi_ctrl.sv
module apm_smi_ctrl
  import apm_smi_pkg::*;
#(
  parameter bit SMM_PRESENT = 1'b1,
  parameter int CFG_BYTES   = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   apm_wr_i,
  input  logic [7:0]             apm_data_i,
  input  logic                   cfg_wr_i,
  input  logic [CFG_BYTES-1:0]   cfg_be_i,
  input  logic [CFG_BYTES*8-1:0] cfg_wdata_i,
  output logic [CFG_BYTES*8-1:0] cfg_rdata_o,
  input  logic                   smi_clr_i,
  output logic                   smi_o,
  output logic                   sci_en_o
);
  apm_cmd_e cmd;
  logic     smi_en;

  apm_cfg_regs #(.SMM_PRESENT(SMM_PRESENT), .CFG_BYTES(CFG_BYTES)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (cfg_wr_i),
    .be_i     (cfg_be_i),
    .wdata_i  (cfg_wdata_i),
    .cfg_o    (cfg_rdata_o),
    .smi_en_o (smi_en)
  );

  apm_cmd_decode u_dec (
    .wr_i   (apm_wr_i),
    .data_i (apm_data_i),
    .cmd_o  (cmd)
  );

  apm_flag_ctrl u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd),
    .smi_en_i  (smi_en),
    .smi_clr_i (smi_clr_i),
    .sci_en_o  (sci_en_o),
    .smi_o     (smi_o)
  );
endmodule

// File: rtl/apm_smi_ctrl_chk.sv
module apm_smi_ctrl_chk
  import apm_smi_pkg::*;
#(
  parameter int CFG_BYTES = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   apm_wr_i,
  input logic [7:0]             apm_data_i,
  input logic [CFG_BYTES*8-1:0] cfg_rdata_o,
  input logic                   smi_clr_i,
  input logic                   smi_o,
  input logic                   sci_en_o
);
  logic is_acpi;
  assign is_acpi = (apm_data_i == APM_ACPI_ON) || (apm_data_i == APM_ACPI_OFF);

  AST_SCI_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apm_wr_i && apm_data_i == APM_ACPI_ON |=> sci_en_o); // R3
  AST_SCI_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apm_wr_i && apm_data_i == APM_ACPI_OFF |=> !sci_en_o); // R3
  AST_SCI_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(apm_wr_i && is_acpi) |=> $stable(sci_en_o)); // R3
  AST_NO_SMI_ACPI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apm_wr_i && is_acpi && !smi_o |=> !smi_o); // R4
  AST_SMI_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apm_wr_i && !is_acpi && cfg_rdata_o[SMI_EN_POS] |=> smi_o); // R5
  AST_SMI_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smi_o && !(apm_wr_i && !is_acpi && cfg_rdata_o[SMI_EN_POS]) |=> !smi_o); // R6
  AST_SMI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o && !smi_clr_i |=> smi_o); // R7
  AST_SMI_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_clr_i && !(apm_wr_i && !is_acpi && cfg_rdata_o[SMI_EN_POS]) |=> !smi_o); // R7
endmodule

bind apm_smi_ctrl apm_smi_ctrl_chk #(.CFG_BYTES(CFG_BYTES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .apm_wr_i    (apm_wr_i),
  .apm_data_i  (apm_data_i),
  .cfg_rdata_o (cfg_rdata_o),
  .smi_clr_i   (smi_clr_i),
  .smi_o       (smi_o),
  .sci_en_o    (sci_en_o)
);

// File: tb/apm_smi_ctrl_tb.sv
module apm_smi_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        apm_wr = 1'b0;
  logic [7:0]  apm_data = 8'h00;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_be = 4'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic        smi_clr = 1'b0;
  logic [31:0] cfg_rdata, n_cfg_rdata;
  logic        smi, sci_en, n_smi, n_sci_en;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  apm_smi_ctrl #(.SMM_PRESENT(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .apm_wr_i(apm_wr), .apm_data_i(apm_data),
    .cfg_wr_i(cfg_wr), .cfg_be_i(cfg_be), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .smi_clr_i(smi_clr), .smi_o(smi), .sci_en_o(sci_en));

  apm_smi_ctrl #(.SMM_PRESENT(1'b0)) u_dut_nosmm (
    .clk_i(clk), .rst_ni(rst_n), .apm_wr_i(apm_wr), .apm_data_i(apm_data),
    .cfg_wr_i(cfg_wr), .cfg_be_i(cfg_be), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(n_cfg_rdata), .smi_clr_i(smi_clr), .smi_o(n_smi), .sci_en_o(n_sci_en));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle of stimulus at negedge; return at the next negedge
  task automatic cycle(logic aw, logic [7:0] ad, logic cw, logic [3:0] be,
                       logic [31:0] wd, logic clr);
    @(negedge clk);
    apm_wr = aw; apm_data = ad; cfg_wr = cw; cfg_be = be; cfg_wdata = wd; smi_clr = clr;
    @(negedge clk);
    apm_wr = 1'b0; cfg_wr = 1'b0; smi_clr = 1'b0;
  endtask

  task automatic set_en(logic en);
    cycle(1'b0, 8'h00, 1'b1, 4'b1000, {6'b0, en, 25'b0}, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic exp_sci;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cfg", cfg_rdata, 32'h0);
    check("R1 smi", {31'b0, smi}, 32'h0);
    check("R1 sci", {31'b0, sci_en}, 32'h0);
    check("R2 cfg", n_cfg_rdata, 32'h0200_0000);
    cycle(1'b1, 8'h55, 1'b0, 4'h0, 32'h0, 1'b0);
    check("R2 smi preset", {31'b0, n_smi}, 32'h1);
    check("R6 smi gated", {31'b0, smi}, 32'h0);

    // R9 byte enables
    cycle(1'b0, 8'h00, 1'b1, 4'b0101, 32'hAABB_CCDD, 1'b0);
    check("R9 be0101", cfg_rdata, 32'h00BB_00DD);
    cycle(1'b0, 8'h00, 1'b1, 4'b1010, 32'h1122_3344, 1'b0);
    check("R9 be1010", cfg_rdata, 32'h11BB_33DD);
    cycle(1'b0, 8'h00, 1'b1, 4'b0000, 32'hFFFF_FFFF, 1'b0);
    check("R9 be0000", cfg_rdata, 32'h11BB_33DD);
    cycle(1'b0, 8'h00, 1'b1, 4'b1111, 32'h0, 1'b0);
    check("R9 be1111", cfg_rdata, 32'h0);

    // R3..R6 sweep of all codes with enable clear and set
    exp_sci = 1'b0;
    for (int en = 0; en < 2; en++) begin
      set_en(en[0]);
      for (int c = 0; c < 256; c++) begin
        cycle(1'b0, 8'h00, 1'b0, 4'h0, 32'h0, 1'b1);
        cycle(1'b1, 8'(c), 1'b0, 4'h0, 32'h0, 1'b0);
        if (c == 'hF1) exp_sci = 1'b1;
        else if (c == 'hF0) exp_sci = 1'b0;
        check("R3 sci", {31'b0, sci_en}, {31'b0, exp_sci});
        if (c == 'hF0 || c == 'hF1)
          check("R4 no smi", {31'b0, smi}, 32'h0);
        else if (en == 1)
          check("R5 smi", {31'b0, smi}, 32'h1);
        else
          check("R6 smi", {31'b0, smi}, 32'h0);
      end
    end

    // R4 with smi enabled and both codes back to back
    cycle(1'b0, 8'h00, 1'b0, 4'h0, 32'h0, 1'b1);
    cycle(1'b1, 8'hF1, 1'b0, 4'h0, 32'h0, 1'b0);
    cycle(1'b1, 8'hF0, 1'b0, 4'h0, 32'h0, 1'b0);
    check("R4 pair", {30'b0, smi, sci_en}, 32'h0);

    // R7 hold and clear
    cycle(1'b1, 8'hB2, 1'b0, 4'h0, 32'h0, 1'b0);
    repeat (5) @(negedge clk);
    check("R7 hold", {31'b0, smi}, 32'h1);
    cycle(1'b0, 8'h00, 1'b0, 4'h0, 32'h0, 1'b1);
    check("R7 clear", {31'b0, smi}, 32'h0);

    // R8 set and clear collide
    cycle(1'b1, 8'hB2, 1'b0, 4'h0, 32'h0, 1'b1);
    check("R8 set wins", {31'b0, smi}, 32'h1);
    cycle(1'b0, 8'h00, 1'b0, 4'h0, 32'h0, 1'b1);

    // R10 same-cycle config write uses old enable
    cycle(1'b1, 8'h33, 1'b1, 4'b1000, 32'h0, 1'b0);
    check("R10 old en=1", {31'b0, smi}, 32'h1);
    check("R10 cfg", cfg_rdata, 32'h0);
    cycle(1'b0, 8'h00, 1'b0, 4'h0, 32'h0, 1'b1);
    cycle(1'b1, 8'h33, 1'b1, 4'b1000, 32'h0200_0000, 1'b0);
    check("R10 old en=0", {31'b0, smi}, 32'h0);
    cycle(1'b1, 8'h33, 1'b0, 4'h0, 32'h0, 1'b0);
    check("R10 new en", {31'b0, smi}, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule